// File: doc/BRIEF.md
# Character Input/Output Bus Slave

This block sits on a processor bus as a memory-mapped slave and gives software access to two character devices: an 8-bit input source, such as a keyboard encoder, and an output device, such as a printer. The input source delivers a character together with a valid strobe. The interface latches the character and raises an "input pending" flag. The processor writes characters to the output device through an output register. An "output ready" flag tells software when the device can take another character.

A bus transfer begins when the master raises master-ready with an address and a read or write command. The upper address bits select the interface against a base address. The two lowest bits pick one of three locations: offset 0 is the input character (read), offset 1 is the output character (write), and offset 2 is the status word (read). The slave answers with slave-ready, one cycle after a decoded access, and holds read data for as long as slave-ready is high. The status flags change as side effects: a read of the input character clears the input flag, a write of the output character clears the output flag, and an acknowledge pulse from the output device sets the output flag again.

Top module: `cio_slave`

## Requirements
- R1: After reset, the input flag is 0, the output flag is 1, slave_rdy is 0 and bus_rdata is 0.
- R2: The interface responds only when bus_addr[ADDR_W-1:2] equals BASE_ADDR[ADDR_W-1:2]. Any other address gives no slave_rdy and changes no flag.
- R3: Only three accesses are decoded: a read at offset 0, a write at offset 1 and a read at offset 2. Every other combination of offset and command gives no slave_rdy and has no effect.
- R4: slave_rdy rises in the cycle after a decoded access is presented with master_rdy high, and stays high while that access lasts. It falls in the cycle after master_rdy falls.
- R5: A rising edge of src_valid, after SYNC_STAGES synchronising flops, latches src_char and sets the input flag. Holding src_valid high does not latch again.
- R6: A read at offset 0 returns the latched character zero-extended in bus_rdata and clears the input flag. If a new character is latched in the same cycle, the flag stays 1.
- R7: A read at offset 2 returns the input flag in bit 0 and the output flag in bit 1. All other bits read as 0.
- R8: A write at offset 1 loads bus_wdata[CHAR_W-1:0] onto dev_char and pulses dev_strobe for one cycle. It also clears the output flag.
- R9: A one-cycle dev_ack pulse sets the output flag. If a write at offset 1 lands in the same cycle, the write wins and the flag is 0.
- R10: A single handshake causes its side effect only once, however long master_rdy is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address from the master |
| bus_rd | input | 1 | Read command |
| bus_wr | input | 1 | Write command |
| bus_wdata | input | DATA_W | Write data |
| master_rdy | input | 1 | Master has a valid request |
| bus_rdata | output | DATA_W | Read data, valid while slave_rdy is high |
| slave_rdy | output | 1 | Slave response handshake |
| src_char | input | CHAR_W | Character from the input source |
| src_valid | input | 1 | Input source strobe, may be asynchronous |
| dev_char | output | CHAR_W | Character presented to the output device |
| dev_strobe | output | 1 | One-cycle pulse when a new character is written |
| dev_ack | input | 1 | Output device has taken the character |

## Verification
The assertions assume the master removes master_rdy between transfers, so that each handshake starts from a low slave_rdy. They also assume bus_rd and bus_wr are never high together. The bench's transfer task enforces both: it raises master_rdy for exactly one command and drops it after slave_rdy is seen. It then idles for a cycle before the next transfer. src_char is held steady for the whole time src_valid is high, and dev_ack is only ever a one-cycle pulse, which matches what the flag logic expects from its devices.

// File: rtl/cio_pkg.sv
package cio_pkg;
   typedef enum logic [1:0] {
      OFF_IN_CHAR  = 2'd0,
      OFF_OUT_CHAR = 2'd1,
      OFF_STATUS   = 2'd2,
      OFF_NONE     = 2'd3
   } cio_off_e;

   localparam int unsigned STAT_IN_BIT  = 0;
   localparam int unsigned STAT_OUT_BIT = 1;
endpackage

// File: rtl/cio_decode.sv
module cio_decode
   import cio_pkg::*;
#(
   parameter int unsigned    ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              master_rdy,
   output logic              hit_in,
   output logic              hit_out,
   output logic              hit_stat,
   output logic              first,
   output logic              slave_rdy
);
   localparam int unsigned TAG_W = ADDR_W - 2;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("cio_decode: ADDR_W must be at least 3");
      end
   endgenerate

   logic     selected;
   cio_off_e off;

   assign selected = (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
   assign off      = cio_off_e'(addr[1:0]);

   assign hit_in   = master_rdy && selected && rd && (off == OFF_IN_CHAR);
   assign hit_out  = master_rdy && selected && wr && (off == OFF_OUT_CHAR);
   assign hit_stat = master_rdy && selected && rd && (off == OFF_STATUS);
   assign first    = (hit_in || hit_out || hit_stat) && !slave_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) slave_rdy <= 1'b0;
      else        slave_rdy <= hit_in || hit_out || hit_stat;
   end

   // R4: response drops one cycle after the request goes away
   a_r4_rdy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !master_rdy |=> !slave_rdy);
   // R4: no response without a request in the cycle before
   a_r4_rdy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      slave_rdy |-> $past(master_rdy));
   // R2: a foreign address never yields a response
   a_r2_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[ADDR_W-1:2] != BASE_ADDR[ADDR_W-1:2]) |=> !slave_rdy);

   logic unused_tag;
   assign unused_tag = (TAG_W == 0);
endmodule

// File: rtl/cio_in_port.sv
module cio_in_port #(
   parameter int unsigned CHAR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] src_char,
   input  logic              src_valid,
   input  logic              rd_clr,
   output logic [CHAR_W-1:0] in_data,
   output logic              in_flag
);
   logic valid_s;
   logic valid_prev;
   logic rise;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign valid_s = src_valid;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
               if (!rst_n) chain <= '0;
               else        chain <= src_valid;
            end
         end else begin : g_many
            always_ff @(posedge clk) begin
               if (!rst_n) chain <= '0;
               else        chain <= {chain[SYNC_STAGES-2:0], src_valid};
            end
         end
         assign valid_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = valid_s && !valid_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_prev <= 1'b0;
         in_data    <= '0;
         in_flag    <= 1'b0;
      end else begin
         valid_prev <= valid_s;
         if (rise) begin
            in_data <= src_char;
            in_flag <= 1'b1;
         end else if (rd_clr) begin
            in_flag <= 1'b0;
         end
      end
   end

   // R5: the flag only rises because of a strobe edge
   a_r5_flag_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_flag) |-> $past(rise));
   // R6: the flag only falls because of a data read
   a_r6_clear_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_flag) |-> $past(rd_clr));
endmodule

// File: rtl/cio_out_port.sv
module cio_out_port #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] wr_char,
   input  logic              wr_fire,
   input  logic              dev_ack,
   output logic [CHAR_W-1:0] dev_char,
   output logic              dev_strobe,
   output logic              out_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_char   <= '0;
         dev_strobe <= 1'b0;
         out_flag   <= 1'b1;
      end else begin
         dev_strobe <= wr_fire;
         if (wr_fire) begin
            dev_char <= wr_char;
            out_flag <= 1'b0;
         end else if (dev_ack) begin
            out_flag <= 1'b1;
         end
      end
   end

   // R9: ready comes back only through an acknowledge
   a_r9_set_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_flag) |-> $past(dev_ack));
   // R8: a strobe always coincides with a busy device
   a_r8_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      dev_strobe |-> !out_flag);
   // R10: a strobe never repeats back to back
   a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      dev_strobe |=> !dev_strobe);
endmodule

// File: rtl/cio_slave.sv
module cio_slave
   import cio_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       CHAR_W      = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h0000_4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              master_rdy,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              slave_rdy,
   input  logic [CHAR_W-1:0] src_char,
   input  logic              src_valid,
   output logic [CHAR_W-1:0] dev_char,
   output logic              dev_strobe,
   input  logic              dev_ack
);
   localparam int unsigned STAT_W = 2;

   generate
      if (CHAR_W < 1 || CHAR_W > DATA_W) begin : g_bad_char
         $error("cio_slave: CHAR_W must be between 1 and DATA_W");
      end
      if (DATA_W < STAT_W) begin : g_bad_data
         $error("cio_slave: DATA_W too narrow for status");
      end
   endgenerate

   logic              hit_in, hit_out, hit_stat, first;
   logic [CHAR_W-1:0] in_data;
   logic              in_flag, out_flag;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] char_word;

   cio_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
      .master_rdy(master_rdy), .hit_in(hit_in), .hit_out(hit_out),
      .hit_stat(hit_stat), .first(first), .slave_rdy(slave_rdy)
   );

   cio_in_port #(.CHAR_W(CHAR_W), .SYNC_STAGES(SYNC_STAGES)) u_in (
      .clk(clk), .rst_n(rst_n), .src_char(src_char), .src_valid(src_valid),
      .rd_clr(first && hit_in), .in_data(in_data), .in_flag(in_flag)
   );

   cio_out_port #(.CHAR_W(CHAR_W)) u_out (
      .clk(clk), .rst_n(rst_n), .wr_char(bus_wdata[CHAR_W-1:0]),
      .wr_fire(first && hit_out), .dev_ack(dev_ack), .dev_char(dev_char),
      .dev_strobe(dev_strobe), .out_flag(out_flag)
   );

   generate
      if (CHAR_W == DATA_W) begin : g_full
         assign char_word = in_data;
      end else begin : g_pad
         assign char_word = {{(DATA_W-CHAR_W){1'b0}}, in_data};
         logic unused_wdata;
         assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];
      end
   endgenerate

   always_comb begin
      stat_word               = '0;
      stat_word[STAT_IN_BIT]  = in_flag;
      stat_word[STAT_OUT_BIT] = out_flag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        bus_rdata <= '0;
      else if (hit_in)   bus_rdata <= char_word;
      else if (hit_stat) bus_rdata <= stat_word;
      else               bus_rdata <= '0;
   end

   // R7: a status answer never carries bits above the two flags
   a_r7_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_rdy && $past(hit_stat)) |-> (bus_rdata[DATA_W-1:STAT_W] == '0));
   // R3: a write answer carries no read data
   a_r3_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit_out) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_cio_slave.sv
module tb_cio_slave;
   localparam logic [31:0] BASE = 32'h0000_4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, master_rdy = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        slave_rdy;
   logic [7:0]  src_char = '0;
   logic        src_valid = 1'b0;
   logic [7:0]  dev_char;
   logic        dev_strobe;
   logic        dev_ack = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cio_slave #(.BASE_ADDR(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .master_rdy(master_rdy),
      .bus_rdata(bus_rdata), .slave_rdy(slave_rdy), .src_char(src_char),
      .src_valid(src_valid), .dev_char(dev_char), .dev_strobe(dev_strobe),
      .dev_ack(dev_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one handshake; returns response, data and strobe seen with the response
   task automatic xfer(input logic [31:0] a, input logic r, input logic w,
                       input logic [31:0] wd, output logic rdy,
                       output logic [31:0] rdv, output logic strb);
      bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = wd; master_rdy = 1'b1;
      @(negedge clk);
      rdy = slave_rdy; rdv = bus_rdata; strb = dev_strobe;
      master_rdy = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
      @(negedge clk);
      chk("R4 drop", {31'd0, slave_rdy}, 32'd0);
      @(negedge clk);
   endtask

   task automatic rd_stat(input string req, input logic [31:0] exp);
      logic r, s; logic [31:0] d;
      xfer(BASE + 32'd2, 1'b1, 1'b0, '0, r, d, s);
      chk({req, " rdy"}, {31'd0, r}, 32'd1);
      chk(req, d, exp);
   endtask

   task automatic press(input logic [7:0] c);
      src_char = c; src_valid = 1'b1;
      repeat (6) @(negedge clk);
      src_valid = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic ack();
      dev_ack = 1'b1; @(negedge clk); dev_ack = 1'b0; @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic r, s; logic [31:0] d; logic [7:0] c; int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdy", {31'd0, slave_rdy}, 32'd0);
      chk("R1 rdata", bus_rdata, 32'd0);
      rd_stat("R1 status", 32'd2);

      // R3 decode sweep over offsets and commands
      for (int off = 0; off < 4; off++) begin
         for (int op = 0; op < 2; op++) begin
            xfer(BASE + off, op == 0, op == 1, 32'h55, r, d, s);
            chk($sformatf("R3 off%0d op%0d", off, op), {31'd0, r},
                {31'd0, (op == 0 && (off == 0 || off == 2)) || (op == 1 && off == 1)});
            if (op == 1 && off == 1) ack();
         end
      end
      rd_stat("R3 no side effect", 32'd2);

      // R2 foreign addresses: flip each upper bit
      for (int k = 2; k < 32; k++) begin
         xfer((BASE + 32'd1) ^ (32'd1 << k), 1'b0, 1'b1, 32'h77, r, d, s);
         chk($sformatf("R2 bit%0d", k), {31'd0, r}, 32'd0);
      end
      rd_stat("R2 flags untouched", 32'd2);

      // R5 R6 R7 capture sweep
      for (int i = 0; i < 16; i++) begin
         c = 8'((i * 29 + 3) & 255);
         press(c);
         rd_stat("R7 pending", 32'd3);
         xfer(BASE, 1'b1, 1'b0, '0, r, d, s);
         chk("R6 char", d, {24'd0, c});
         rd_stat("R6 cleared", 32'd2);
      end

      // R5 held strobe does not reload
      src_char = 8'hA1; src_valid = 1'b1;
      repeat (6) @(negedge clk);
      xfer(BASE, 1'b1, 1'b0, '0, r, d, s);
      chk("R5 first", d, 32'hA1);
      src_char = 8'hB2;
      repeat (6) @(negedge clk);
      rd_stat("R5 held no reload", 32'd2);
      src_valid = 1'b0;
      repeat (4) @(negedge clk);

      // R6 capture coinciding with read clear: capture wins
      src_char = 8'hC3; src_valid = 1'b1;
      @(negedge clk); @(negedge clk);
      xfer(BASE, 1'b1, 1'b0, '0, r, d, s);
      chk("R6 old char", d, 32'hA1);
      src_valid = 1'b0;
      rd_stat("R6 capture wins", 32'd3);
      xfer(BASE, 1'b1, 1'b0, '0, r, d, s);
      chk("R6 new char", d, 32'hC3);

      // R8 R9 output sweep
      for (int i = 0; i < 8; i++) begin
         c = 8'((i * 53 + 17) & 255);
         xfer(BASE + 32'd1, 1'b0, 1'b1, {24'hDEAD_BE, c}, r, d, s);
         chk("R8 rdy", {31'd0, r}, 32'd1);
         chk("R8 strobe", {31'd0, s}, 32'd1);
         chk("R8 char", {24'd0, dev_char}, {24'd0, c});
         chk("R8 strobe once", {31'd0, dev_strobe}, 32'd0);
         rd_stat("R8 busy", 32'd0);
         ack();
         rd_stat("R9 ready", 32'd2);
      end

      // R9 write and ack in the same cycle: write wins
      bus_addr = BASE + 32'd1; bus_wr = 1'b1; bus_wdata = 32'h3C;
      master_rdy = 1'b1; dev_ack = 1'b1;
      @(negedge clk);
      dev_ack = 1'b0; master_rdy = 1'b0; bus_wr = 1'b0;
      repeat (2) @(negedge clk);
      rd_stat("R9 write wins", 32'd0);
      ack();

      // R10 long handshake: one strobe, one clear
      bus_addr = BASE + 32'd1; bus_wr = 1'b1; bus_wdata = 32'h4D; master_rdy = 1'b1;
      cnt = 0;
      for (int t = 0; t < 5; t++) begin
         @(negedge clk);
         if (dev_strobe) cnt++;
      end
      chk("R4 held", {31'd0, slave_rdy}, 32'd1);
      master_rdy = 1'b0; bus_wr = 1'b0;
      @(negedge clk);
      if (dev_strobe) cnt++;
      chk("R10 one strobe", cnt, 32'd1);
      ack();
      press(8'h6E);
      bus_addr = BASE; bus_rd = 1'b1; master_rdy = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10 data held", bus_rdata, 32'h6E);
      master_rdy = 1'b0; bus_rd = 1'b0;
      repeat (2) @(negedge clk);
      rd_stat("R10 cleared once", 32'd2);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule